// File: doc/BRIEF.md
# Carrier Modulator with Selectable Polarity

This block gates a programmable square carrier onto a baseband pulse stream. The carrier spends a configurable number of clock cycles high, then a configurable number low, and repeats. The modulated output follows the carrier only where modulation applies. Everywhere else it follows the baseband level.

Whether modulation applies depends on three settings. A polarity setting puts the carrier on either the high or the low baseband level. An active-only setting limits modulation to periods when the data-active flag is set, or allows it in every state, idle included. An enable setting turns modulation on or off.

The settings are held in internal registers. They are loaded from the configuration inputs on a write strobe and take their defaults at reset. Each time modulation starts, the carrier restarts at the beginning of its high phase, so the first carrier period is always complete. The output is registered.

Top module: `carrier_mod`

## Requirements
- R1: Until the first configuration write after reset, the held settings are: enable 1, polarity 1, active-only 1, high time 64 cycles and low time 64 cycles.
- R2: When `cfgWrite` is 1 at a rising clock edge, the values on the `cfg*` inputs are held from that edge onward. They govern the output produced at the following edge.
- R3: With enable 0, `modOut` equals the `baseLevel` value sampled at the previous rising edge.
- R4: Modulation applies only while `baseLevel` equals the polarity setting. Polarity 1 places the carrier on the high level and polarity 0 on the low level. Where modulation does not apply, `modOut` is the previous-edge `baseLevel`.
- R5: With active-only 1, modulation applies only while `dataActive` is 1. With active-only 0, modulation applies whatever the value of `dataActive`.
- R6: While modulation applies, `modOut` is 1 for the high time in cycles, then 0 for the low time in cycles, and the pattern repeats.
- R7: In the first cycle that modulation applies after a cycle where it did not, the carrier restarts: `modOut` at the next edge is 1 and a full high phase follows.
- R8: A high time or low time of 0 is treated as 1 cycle.
- R9: The output is registered with one cycle of latency. `modOut` is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Loads the cfg* inputs into the held settings |
| cfgEnable | input | 1 | Modulation enable |
| cfgOnHigh | input | 1 | Carrier polarity: 1 = on the high level, 0 = on the low level |
| cfgActiveOnly | input | 1 | 1 = modulate only while data is active |
| cfgHighTime | input | TIME_W | Carrier high time in cycles |
| cfgLowTime | input | TIME_W | Carrier low time in cycles |
| baseLevel | input | 1 | Baseband level |
| dataActive | input | 1 | Data is being sent |
| modOut | output | 1 | Modulated output |

## Verification
The bench builds the block with its default parameters: TIME_W = 16 and a default time of 64. This makes the full 64/64 reset waveform reachable over more than one period. Short programmed times (3/2, 0/0 and 0/3) keep each pattern change within a few cycles, so restart, polarity and active-only gating can be exercised densely. The zero-time case checks that the carrier degenerates to a cycle-by-cycle toggle.

// File: rtl/carrier_mod_pkg.sv
package carrier_mod_pkg;
  localparam int TIME_W_DEF = 16;
  localparam int RESET_TIME_DEF = 64;

  typedef struct packed {
    logic apply;
    logic restart;
  } modStrobe_t;
endpackage

// File: rtl/carrier_mod_ctrl.sv
module carrier_mod_ctrl
  import carrier_mod_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF,
  parameter int RESET_TIME = RESET_TIME_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic              cfgEnable,
  input  logic              cfgOnHigh,
  input  logic              cfgActiveOnly,
  input  logic [TIME_W-1:0] cfgHighTime,
  input  logic [TIME_W-1:0] cfgLowTime,
  input  logic              baseLevel,
  input  logic              dataActive,
  output modStrobe_t        strb,
  output logic [TIME_W-1:0] highLen,
  output logic [TIME_W-1:0] lowLen
);
  localparam logic [TIME_W-1:0] RstTime = TIME_W'(RESET_TIME);
  localparam logic [TIME_W-1:0] OneCycle = TIME_W'(1);

  logic              enReg, polReg, actReg, applyPrev, applyNow;
  logic [TIME_W-1:0] hiReg, loReg;

  // held settings, loaded on write strobe (R1, R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg  <= 1'b1;
      polReg <= 1'b1;
      actReg <= 1'b1;
      hiReg  <= RstTime;
      loReg  <= RstTime;
    end else if (cfgWrite) begin
      enReg  <= cfgEnable;
      polReg <= cfgOnHigh;
      actReg <= cfgActiveOnly;
      hiReg  <= cfgHighTime;
      loReg  <= cfgLowTime;
    end
  end

  // zero programmed time is stretched to one cycle (R8)
  always_comb begin
    highLen = (hiReg == '0) ? OneCycle : hiReg;
    lowLen  = (loReg == '0) ? OneCycle : loReg;
  end

  // modulation window (R3, R4, R5)
  always_comb begin
    applyNow = enReg && (baseLevel == polReg) && (!actReg || dataActive);
    strb.apply   = applyNow;
    strb.restart = applyNow && !applyPrev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) applyPrev <= 1'b0;
    else        applyPrev <= applyNow;
  end

  assert_disabled_no_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enReg |-> !strb.apply);
  assert_polarity_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.apply |-> (baseLevel == polReg));
  assert_active_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (actReg && !dataActive) |-> !strb.apply);
endmodule

// File: rtl/carrier_mod_dp.sv
module carrier_mod_dp
  import carrier_mod_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  modStrobe_t        strb,
  input  logic [TIME_W-1:0] highLen,
  input  logic [TIME_W-1:0] lowLen,
  input  logic              baseLevel,
  output logic              modOut
);
  localparam logic [TIME_W-1:0] OneCycle = TIME_W'(1);

  logic              phaseHigh;
  logic [TIME_W-1:0] cnt;
  logic [TIME_W-1:0] curLen;

  assign curLen = phaseHigh ? highLen : lowLen;

  // carrier phase counter and registered output mux (R6, R7, R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
      modOut    <= 1'b0;
    end else if (strb.restart) begin
      phaseHigh <= 1'b1;
      cnt       <= OneCycle;
      modOut    <= 1'b1;
    end else if (strb.apply) begin
      if (cnt >= curLen) begin
        phaseHigh <= !phaseHigh;
        cnt       <= OneCycle;
        modOut    <= !phaseHigh;
      end else begin
        cnt    <= cnt + OneCycle;
        modOut <= phaseHigh;
      end
    end else begin
      cnt    <= '0;
      modOut <= baseLevel;
    end
  end

  assert_restart_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> modOut);
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.apply |=> (modOut == $past(baseLevel)));
  assert_count_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.apply && !strb.restart) |-> (cnt != '0));
endmodule

// File: rtl/carrier_mod.sv
module carrier_mod
  import carrier_mod_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF,
  parameter int RESET_TIME = RESET_TIME_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrite,
  input  logic              cfgEnable,
  input  logic              cfgOnHigh,
  input  logic              cfgActiveOnly,
  input  logic [TIME_W-1:0] cfgHighTime,
  input  logic [TIME_W-1:0] cfgLowTime,
  input  logic              baseLevel,
  input  logic              dataActive,
  output logic              modOut
);
  modStrobe_t        strb;
  logic [TIME_W-1:0] highLen, lowLen;

  carrier_mod_ctrl #(.TIME_W(TIME_W), .RESET_TIME(RESET_TIME)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .cfgOnHigh(cfgOnHigh), .cfgActiveOnly(cfgActiveOnly),
    .cfgHighTime(cfgHighTime), .cfgLowTime(cfgLowTime),
    .baseLevel(baseLevel), .dataActive(dataActive),
    .strb(strb), .highLen(highLen), .lowLen(lowLen)
  );

  carrier_mod_dp #(.TIME_W(TIME_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .highLen(highLen),
    .lowLen(lowLen), .baseLevel(baseLevel), .modOut(modOut)
  );
endmodule

// File: tb/carrier_mod_tb_top.sv
module carrier_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  typedef struct {
    logic  exp;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrite = 1'b0, cfgEnable = 1'b0, cfgOnHigh = 1'b0, cfgActiveOnly = 1'b0;
  logic [TW-1:0] cfgHighTime = '0, cfgLowTime = '0;
  logic baseLevel = 1'b0, dataActive = 1'b0;
  logic modOut;

  int errors = 0;
  int checks = 0;
  expItem_t sbQ[$];

  // reference model state
  logic mEn = 1'b1, mPol = 1'b1, mAct = 1'b1;
  int   mH = 64, mL = 64;
  logic mPrevApply = 1'b0;
  int   mPos = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  carrier_mod dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .cfgOnHigh(cfgOnHigh), .cfgActiveOnly(cfgActiveOnly),
    .cfgHighTime(cfgHighTime), .cfgLowTime(cfgLowTime),
    .baseLevel(baseLevel), .dataActive(dataActive), .modOut(modOut)
  );

  task automatic checkVal(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: modOut=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus plus expected value into the scoreboard
  task automatic drive(input logic base, input logic act, input logic wr,
                       input logic en, input logic pol, input logic ao,
                       input int h, input int l, input string tag);
    logic apply;
    int hn, ln;
    expItem_t it;
    @(negedge clk);
    baseLevel = base; dataActive = act; cfgWrite = wr;
    cfgEnable = en; cfgOnHigh = pol; cfgActiveOnly = ao;
    cfgHighTime = TW'(h); cfgLowTime = TW'(l);
    apply = mEn && (base == mPol) && (!mAct || act);
    hn = (mH == 0) ? 1 : mH;
    ln = (mL == 0) ? 1 : mL;
    if (apply) begin
      mPos = mPrevApply ? mPos + 1 : 0;
      it.exp = ((mPos % (hn + ln)) < hn);
    end else begin
      it.exp = base;
    end
    mPrevApply = apply;
    it.tag = tag;
    sbQ.push_back(it);
    if (wr) begin
      mEn = en; mPol = pol; mAct = ao; mH = h; mL = l;
    end
  endtask

  task automatic setCfg(input logic en, input logic pol, input logic ao,
                        input int h, input int l, input string tag);
    drive(1'b0, 1'b0, 1'b1, en, pol, ao, h, l, tag);
  endtask

  task automatic run(input logic base, input logic act, input int n, input string tag);
    for (int i = 0; i < n; i++) drive(base, act, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
  endtask

  // monitor: compare each result away from the active edge
  always @(posedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      checkVal(modOut, it.exp, it.tag);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal(modOut, 1'b0, "R9 reset");
    rst_n = 1'b1;

    // R1 defaults: 64 high / 64 low on high level with data active
    run(1'b1, 1'b1, 140, "R1 R6 default waveform");
    // R1 active-only default: no carrier without data active
    run(1'b1, 1'b0, 5, "R1 R5 default gate");
    run(1'b0, 1'b1, 3, "R1 R4 default polarity");

    // R3 disabled: pass-through
    setCfg(1'b0, 1'b1, 1'b0, 3, 2, "R2 write disable");
    for (int i = 0; i < 12; i++) run(logic'(i % 3 == 0), 1'b1, 1, "R3 passthru");

    // R4 polarity high, active-only off, base pulses restart carrier
    setCfg(1'b1, 1'b1, 1'b0, 3, 2, "R2 write high");
    for (int k = 0; k < 3; k++) begin
      run(1'b1, 1'b0, 7 + k, "R5 R6 R7 on high");
      run(1'b0, 1'b0, 3, "R4 low passes");
    end

    // R4 polarity low
    setCfg(1'b1, 1'b0, 1'b0, 3, 2, "R2 write low");
    run(1'b0, 1'b0, 9, "R4 carrier on low");
    run(1'b1, 1'b0, 4, "R4 high passes");
    run(1'b0, 1'b1, 6, "R7 restart on low");

    // R5 active-only with toggling data-active
    setCfg(1'b1, 1'b1, 1'b1, 3, 2, "R2 write active-only");
    for (int k = 0; k < 4; k++) begin
      run(1'b1, 1'b1, 6, "R5 active");
      run(1'b1, 1'b0, 3, "R5 inactive");
    end

    // R8 zero times
    setCfg(1'b1, 1'b1, 1'b0, 0, 0, "R2 write zero");
    run(1'b1, 1'b0, 10, "R8 zero both");
    setCfg(1'b1, 1'b1, 1'b0, 0, 3, "R2 write zero high");
    run(1'b1, 1'b0, 12, "R8 zero high");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: modOut=%0b expected completion", modOut);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule